// File: doc/BRIEF.md
# Byte-Access Down-Counter Timer Channel

This block is a single channel of a programmable interval timer. It is built around a 16-bit synchronous down counter. The host cannot reach the counter directly. It sees the channel only through an 8-bit bus that carries a control byte, a staging register for the new count, and a read-side snapshot register.

Counts are written one byte at a time into the staging register. Both staged bytes move into the counter together, on a single cycle. Reads come from the snapshot register. That register trails the counter by one clock until the host freezes it with a latch command. It stays frozen until the frozen value has been fully read back, and then it starts trailing the counter again.

A status byte holds three things: the control byte, the output pin level and a flag that marks a pending count. The host reads it at the control address.

The counter steps down by one on each clock while the gate input is high. It stops at zero, and the output goes high when zero is reached. Several channels share one bus. Each instance is given its own channel number, and the two channel-select bits of a control byte are compared with that number.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is low and the status byte reads 0x00. While the stored access format is 00 (unprogrammed), count writes to the channel address have no effect.
- R2: A write to address 3 is a control byte. It applies only when its bits 7:6 equal the channel number. Bits 5:4 select the access format: 00 = latch command, 01 = low byte only, 10 = high byte only, 11 = low then high. For formats 01 to 11, bits 5:0 are stored.
- R3: In format 01 a count write loads the low byte and zeroes the high byte. In format 10 it loads the high byte and zeroes the low byte. In format 11 the first write loads the low byte and the second loads the high byte. The staged 16-bit value enters the counter on the clock after the completing write, and not before.
- R4: The pending flag (status bit 6) is set by any accepted control byte of format 01 to 11 and by any count byte write. It clears when the staged value enters the counter.
- R5: The counter decrements by one per clock while gate is high and the counter is nonzero. It holds at zero, and it holds while gate is low.
- R6: The output drops low on an accepted control byte of format 01 to 11. It goes high on the clock at which the counter reaches zero, including a load of zero. Otherwise it holds.
- R7: While not frozen, the snapshot register takes the counter value one clock later, and reads return it.
- R8: A latch command freezes the snapshot at the present count. Further latch commands are ignored while it is frozen. It is released once the frozen value has been read: one read in formats 01 and 10, the second read in format 11. An accepted control byte also releases it.
- R9: In format 11, count reads alternate low byte then high byte. Format 01 always reads the low byte and format 10 always reads the high byte. An accepted control byte restarts both the read and the write byte order at the low byte.
- R10: A read at address 3 returns the status byte. Bit 7 is the output level, bit 6 is the pending flag and bits 5:0 are the stored control bits.
- R11: Writes at other counter addresses, writes with chip select low, and control bytes for another channel leave this channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the count clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select |
| addr_i | input | 2 | Register address (3 = control/status) |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, valid while cs_i and rd_i are high |
| gate_i | input | 1 | Count enable |
| out_o | output | 1 | Terminal-count output |

## Verification
The bench builds the channel with CHAN_ID = 1 and BYTE_W = 8. With CHAN_ID = 1, one neighbour address lies below this channel and one above it, and control bytes aimed at channels 0 and 2 can be sent. Both neighbours are exercised to confirm they leave this channel alone. With an 8-bit byte width, every byte of a full 16-bit count can be checked by hand, along with a count of one, a count of zero and the stop at zero.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  localparam int unsigned CTRL_W = 6;
endpackage

// File: rtl/pit_ctrl_word.sv
module pit_ctrl_word
  import pit_pkg::*;
#(
  parameter int unsigned CHAN_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_wr_i,
  input  logic [7:0]        data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output acc_e              acc_o,
  output logic              cw_load_o,
  output logic              latch_cmd_o
);
  localparam logic [1:0] CHAN_SEL = CHAN_ID[1:0];

  logic              hit;
  logic [CTRL_W-1:0] ctrl_q;

  assign hit         = cw_wr_i && (data_i[7:6] == CHAN_SEL);
  assign latch_cmd_o = hit && (data_i[5:4] == ACC_LATCH);
  assign cw_load_o   = hit && (data_i[5:4] != ACC_LATCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (cw_load_o) ctrl_q <= data_i[CTRL_W-1:0];
  end

  assign ctrl_o = ctrl_q;
  assign acc_o  = acc_e'(ctrl_q[5:4]);

  AST_CW_FOREIGN_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw_wr_i && data_i[7:6] != CHAN_SEL) |=> $stable(ctrl_q)); // R11
endmodule

// File: rtl/pit_count_load.sv
module pit_count_load
  import pit_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_load_i,
  input  logic              cnt_wr_i,
  input  acc_e              acc_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CNT_W-1:0]  cr_o,
  output logic              load_o,
  output logic              null_o
);
  logic [BYTE_W-1:0] cr_lo_q, cr_hi_q;
  logic              wr_ff_q, xfer_q, null_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_lo_q <= '0;
      cr_hi_q <= '0;
      wr_ff_q <= 1'b0;
      xfer_q  <= 1'b0;
      null_q  <= 1'b0;
    end else begin
      xfer_q <= 1'b0;
      if (xfer_q) null_q <= 1'b0;
      if (cw_load_i) begin
        wr_ff_q <= 1'b0;
        null_q  <= 1'b1;
      end else if (cnt_wr_i) begin
        null_q <= 1'b1;
        unique case (acc_i)
          ACC_LO: begin
            cr_lo_q <= data_i;
            cr_hi_q <= '0;
            xfer_q  <= 1'b1;
          end
          ACC_HI: begin
            cr_lo_q <= '0;
            cr_hi_q <= data_i;
            xfer_q  <= 1'b1;
          end
          ACC_WORD: begin
            if (!wr_ff_q) begin
              cr_lo_q <= data_i;
              wr_ff_q <= 1'b1;
            end else begin
              cr_hi_q <= data_i;
              wr_ff_q <= 1'b0;
              xfer_q  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cr_o   = {cr_hi_q, cr_lo_q};
  assign load_o = xfer_q;
  assign null_o = null_q;

  AST_NULL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_q && !cw_load_i && !cnt_wr_i) |=> !null_q); // R4
  AST_WRFF_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_load_i |=> !wr_ff_q); // R9
  AST_XFER_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_q |-> $past(cnt_wr_i)); // R3
endmodule

// File: rtl/pit_count_elem.sv
module pit_count_elem #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cr_i,
  input  logic             cw_load_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] ce_o,
  output logic             out_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] ce_q;
  logic             out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q  <= '0;
      out_q <= 1'b0;
    end else if (load_i) begin
      ce_q  <= cr_i;
      out_q <= (cr_i == '0);
    end else if (cw_load_i) begin
      out_q <= 1'b0;
    end else if (gate_i && ce_q != '0) begin
      ce_q  <= ce_q - ONE;
      out_q <= (ce_q == ONE);
    end
  end

  assign ce_o  = ce_q;
  assign out_o = out_q;

  AST_HOLD_NO_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !load_i) |=> $stable(ce_q)); // R5
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_q == '0 && !load_i) |=> (ce_q == '0)); // R5
  AST_OUT_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q |-> (ce_q == '0)); // R6
endmodule

// File: rtl/pit_out_latch.sv
module pit_out_latch
  import pit_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  ce_i,
  input  logic              latch_cmd_i,
  input  logic              cw_load_i,
  input  logic              cnt_rd_i,
  input  acc_e              acc_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [CNT_W-1:0] ol_q;
  logic             frozen_q, rd_ff_q, release_rd;

  always_comb begin
    release_rd = 1'b0;
    if (cnt_rd_i) release_rd = (acc_i != ACC_WORD) || rd_ff_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ol_q     <= '0;
      frozen_q <= 1'b0;
      rd_ff_q  <= 1'b0;
    end else begin
      if (!frozen_q) ol_q <= ce_i;
      if (cw_load_i) begin
        frozen_q <= 1'b0;
        rd_ff_q  <= 1'b0;
      end else begin
        if (latch_cmd_i && !frozen_q) frozen_q <= 1'b1;
        if (cnt_rd_i && acc_i == ACC_WORD) rd_ff_q <= !rd_ff_q;
        if (release_rd) frozen_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (acc_i)
      ACC_HI:   byte_o = ol_q[CNT_W-1:BYTE_W];
      ACC_WORD: byte_o = rd_ff_q ? ol_q[CNT_W-1:BYTE_W] : ol_q[BYTE_W-1:0];
      default:  byte_o = ol_q[BYTE_W-1:0];
    endcase
  end

  AST_FROZEN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_q |=> $stable(ol_q)); // R8
  AST_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frozen_q |=> (ol_q == $past(ce_i))); // R7
  AST_RDFF_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_load_i |=> !rd_ff_q); // R9
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int unsigned CHAN_ID = 0,
  parameter int unsigned BYTE_W  = 8,
  localparam int unsigned CNT_W  = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] data_o,
  input  logic              gate_i,
  output logic              out_o
);
  localparam logic [1:0] CHAN_SEL = CHAN_ID[1:0];
  localparam logic [1:0] CTRL_ADR = 2'b11;

  logic              cw_wr, cnt_wr, cnt_rd, at_chan;
  logic              cw_load, latch_cmd, load, null_flag;
  acc_e              acc;
  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  cr, ce;
  logic [BYTE_W-1:0] cnt_byte;
  logic [7:0]        status;

  assign at_chan = cs_i && (addr_i == CHAN_SEL);
  assign cw_wr   = cs_i && wr_i && (addr_i == CTRL_ADR);
  assign cnt_wr  = at_chan && wr_i && (acc != ACC_LATCH);
  assign cnt_rd  = at_chan && rd_i && (acc != ACC_LATCH);

  pit_ctrl_word #(.CHAN_ID(CHAN_ID)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cw_wr_i     (cw_wr),
    .data_i      (data_i[7:0]),
    .ctrl_o      (ctrl),
    .acc_o       (acc),
    .cw_load_o   (cw_load),
    .latch_cmd_o (latch_cmd)
  );

  pit_count_load #(.BYTE_W(BYTE_W)) u_load (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cw_load_i (cw_load),
    .cnt_wr_i  (cnt_wr),
    .acc_i     (acc),
    .data_i    (data_i),
    .cr_o      (cr),
    .load_o    (load),
    .null_o    (null_flag)
  );

  pit_count_elem #(.CNT_W(CNT_W)) u_elem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .cr_i      (cr),
    .cw_load_i (cw_load),
    .gate_i    (gate_i),
    .ce_o      (ce),
    .out_o     (out_o)
  );

  pit_out_latch #(.BYTE_W(BYTE_W)) u_olat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_i        (ce),
    .latch_cmd_i (latch_cmd),
    .cw_load_i   (cw_load),
    .cnt_rd_i    (cnt_rd),
    .acc_i       (acc),
    .byte_o      (cnt_byte)
  );

  assign status = {out_o, null_flag, ctrl};

  always_comb begin
    data_o = '0;
    if (cs_i && rd_i) begin
      if (addr_i == CTRL_ADR)      data_o = BYTE_W'(status);
      else if (addr_i == CHAN_SEL) data_o = cnt_byte;
    end
  end

  AST_LOAD_NEEDS_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc == ACC_LATCH) |-> !cnt_wr); // R1
  AST_STATUS_OUT_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == CTRL_ADR) |-> (data_o[7] == out_o)); // R10
endmodule

// File: tb/tb_pit_channel.sv
module tb_pit_channel;
  localparam int unsigned BYTE_W = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, gate_i = 1'b0;
  logic [1:0] addr_i = 2'b00;
  logic [7:0] data_i = 8'h00;
  logic [7:0] data_o;
  logic       out_o;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk_i = ~clk_i;

  pit_channel #(.CHAN_ID(1), .BYTE_W(BYTE_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .data_i(data_i), .data_o(data_o),
    .gate_i(gate_i), .out_o(out_o)
  );

  task automatic wr_bus(input logic [1:0] a, input logic [7:0] d, input logic cs = 1'b1);
    @(negedge clk_i);
    cs_i = cs; addr_i = a; data_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic rd_bus(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    cs_i = 1'b1; addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_gate(input int k);
    @(negedge clk_i);
    gate_i = 1'b1;
    repeat (k) @(posedge clk_i);
    @(negedge clk_i);
    gate_i = 1'b0;
  endtask

  task automatic chk_out(input logic exp, input string tag);
    @(negedge clk_i);
    #3;
    n_chk++;
    if (out_o !== exp) begin
      n_fail++;
      $display("FAIL %s out_o actual=%0b expected=%0b", tag, out_o, exp);
    end
  endtask

  // monitor: pops one expected byte per read strobe
  initial begin
    forever begin
      @(negedge clk_i);
      #3;
      if (cs_i && rd_i) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL scoreboard empty actual=%02h expected=none", data_o);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (data_o !== e) begin
            n_fail++;
            $display("FAIL %s data_o actual=%02h expected=%02h", t, data_o, e);
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    chk_out(1'b0, "R1 reset out");
    rd_bus(2'd3, 8'h00, "R1 reset status");
    wr_bus(2'd1, 8'h55);                       // unprogrammed: ignored
    idle(2);
    rd_bus(2'd3, 8'h00, "R1 count write before control");
    rd_bus(2'd1, 8'h00, "R1 counter untouched");
    wr_bus(2'd3, 8'h30);                       // channel 0 control
    idle(1);
    rd_bus(2'd3, 8'h00, "R11 foreign control byte");

    wr_bus(2'd3, 8'h70);                       // ch1, low-then-high
    rd_bus(2'd3, 8'h70, "R2 R4 status after control");
    wr_bus(2'd1, 8'h34);
    wr_bus(2'd1, 8'h12);
    idle(3);
    rd_bus(2'd3, 8'h30, "R4 pending cleared after transfer");
    rd_bus(2'd1, 8'h34, "R9 low byte first");
    rd_bus(2'd1, 8'h12, "R9 high byte second");

    wr_bus(2'd3, 8'h40);                       // latch command
    pulse_gate(5);                             // ce = 0x122F
    rd_bus(2'd1, 8'h34, "R8 frozen low");
    rd_bus(2'd1, 8'h12, "R8 frozen high");
    idle(2);
    rd_bus(2'd1, 8'h2F, "R5 R7 follow after release low");
    rd_bus(2'd1, 8'h12, "R7 follow after release high");
    wr_bus(2'd3, 8'h40);
    pulse_gate(3);                             // ce = 0x122C
    wr_bus(2'd3, 8'h40);                       // ignored while frozen
    rd_bus(2'd1, 8'h2F, "R8 second latch ignored low");
    rd_bus(2'd1, 8'h12, "R8 second latch ignored high");
    idle(2);
    rd_bus(2'd1, 8'h2C, "R5 count after gate low");
    rd_bus(2'd1, 8'h12, "R5 count after gate high");
    rd_bus(2'd3, 8'h30, "R10 status unchanged by latch");

    wr_bus(2'd3, 8'h50);                       // low byte only
    rd_bus(2'd3, 8'h50, "R10 status low-only pending");
    wr_bus(2'd1, 8'h03);
    idle(2);
    rd_bus(2'd1, 8'h03, "R9 low-only read");
    rd_bus(2'd1, 8'h03, "R9 low-only no alternation");
    chk_out(1'b0, "R6 out low while counting");
    pulse_gate(3);
    chk_out(1'b1, "R6 out high at zero");
    rd_bus(2'd3, 8'h90, "R10 status out high");
    pulse_gate(2);
    idle(1);
    rd_bus(2'd1, 8'h00, "R5 holds at zero");
    chk_out(1'b1, "R6 out holds");

    wr_bus(2'd3, 8'h60);                       // high byte only
    chk_out(1'b0, "R6 control drops out");
    wr_bus(2'd1, 8'h02);
    idle(2);
    rd_bus(2'd1, 8'h02, "R3 high-only read");
    wr_bus(2'd3, 8'h70);
    rd_bus(2'd1, 8'h00, "R3 low byte zeroed");
    rd_bus(2'd1, 8'h02, "R9 order restarted by control");

    wr_bus(2'd1, 8'h99);                       // first byte only
    idle(2);
    rd_bus(2'd3, 8'h70, "R4 pending after one byte");
    rd_bus(2'd1, 8'h00, "R3 no transfer on first byte low");
    rd_bus(2'd1, 8'h02, "R3 no transfer on first byte high");
    wr_bus(2'd1, 8'h00);
    idle(2);
    rd_bus(2'd3, 8'h30, "R4 pending cleared");
    rd_bus(2'd1, 8'h99, "R3 two-byte load low");
    rd_bus(2'd1, 8'h00, "R3 two-byte load high");

    wr_bus(2'd0, 8'h77);
    wr_bus(2'd2, 8'h11);
    wr_bus(2'd1, 8'h55, 1'b0);
    wr_bus(2'd3, 8'hB0);                       // channel 2 control
    idle(2);
    rd_bus(2'd3, 8'h30, "R11 status after foreign writes");
    rd_bus(2'd1, 8'h99, "R11 count kept low");
    rd_bus(2'd1, 8'h00, "R11 count kept high");

    wr_bus(2'd3, 8'h50);
    wr_bus(2'd1, 8'h00);
    idle(1);
    chk_out(1'b1, "R6 load of zero");

    wr_bus(2'd3, 8'h70);
    wr_bus(2'd1, 8'h02);
    wr_bus(2'd1, 8'h00);
    idle(1);
    pulse_gate(1);
    chk_out(1'b0, "R6 one step before zero");
    pulse_gate(1);
    chk_out(1'b1, "R6 reaches zero");

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule